// File: doc/BRIEF.md
# Serial Receive Queue with Ready, Error and Request Logic

This block sits behind a serial receiver's shift register and in front of the port that software or a DMA channel uses to take received characters. Each completed character arrives with a one-cycle valid strobe, together with its parity-error and framing-error indications. The block holds these characters in a small first-in, first-out queue. The queue only adds margin against overruns. Every entry keeps its own error bits next to its data byte.

The block drives a data-ready flag and three sticky error flags: parity, framing and overrun. From these and a few control inputs it builds a receive interrupt request and a DMA request. The DMA request is held off while any error flag is up. A DMA channel therefore stops with the faulty character at the head of the queue, where software can find it. The data-ready cause of the interrupt can be masked by an inhibit input. The error causes and an auxiliary cause, such as a carrier-detect change, stay live while it is masked.

Top module: `rx_fifo_status`

## Requirements
- R1: After reset the queue is empty, and data_rdy, all three error flags, irq and dma_req are 0.
- R2: A character offered on chr_vld while the queue is not full is stored. data_rdy is 1 in the cycle after the strobe. Reads return characters oldest first, and rd_data, rd_perr and rd_ferr always show the oldest entry.
- R3: After a read (rd_stb for one cycle), data_rdy stays 1 while entries remain, and so does irq when it is enabled. data_rdy drops to 0 in the cycle after the last entry is read.
- R4: The queue holds DEPTH characters (default 4). A character that arrives while the queue is full, with no read in the same cycle, is discarded and ovr_flag is set. The stored entries are left unchanged.
- R5: perr_flag (or ferr_flag) is 1 in any cycle where the oldest entry carries a parity (or framing) error. An errored entry further back does not raise the flag.
- R6: Once set, each error flag stays set until an err_clr pulse. A clear does not remove perr_flag or ferr_flag while an errored entry is still the oldest.
- R7: dma_req is 1 exactly when data_rdy is 1 and none of perr_flag, ferr_flag and ovr_flag is set.
- R8: With rdy_int_inhibit at 0 and rx_int_en at 1, data_rdy raises irq.
- R9: With rdy_int_inhibit at 1, data_rdy alone does not raise irq. Any error flag or aux_cause still raises irq while rx_int_en is 1.
- R10: With rx_int_en at 0, irq is 0 whatever the other causes are.
- R11: A read strobe while the queue is empty is ignored. data_rdy stays 0 and the next character stored is read back correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chr_vld | input | 1 | One-cycle strobe: a completed character is offered |
| chr_data | input | 8 | Received character |
| chr_perr | input | 1 | Parity error of the offered character |
| chr_ferr | input | 1 | Framing error of the offered character |
| rd_stb | input | 1 | Read strobe: removes the oldest entry |
| err_clr | input | 1 | Clears the sticky error flags |
| rx_int_en | input | 1 | Receive interrupt enable |
| rdy_int_inhibit | input | 1 | Masks data_rdy as an interrupt cause |
| aux_cause | input | 1 | Extra interrupt cause, e.g. carrier detect |
| rd_data | output | 8 | Data of the oldest entry |
| rd_perr | output | 1 | Parity error bit of the oldest entry |
| rd_ferr | output | 1 | Framing error bit of the oldest entry |
| data_rdy | output | 1 | Queue holds at least one character |
| perr_flag | output | 1 | Parity error flag |
| ferr_flag | output | 1 | Framing error flag |
| ovr_flag | output | 1 | Overrun flag |
| irq | output | 1 | Receive interrupt request |
| dma_req | output | 1 | Receive DMA request |

## Verification
On every cycle, the assertions check these relations:
- dma_req stays low while an error flag is set.
- irq stays low when interrupts are disabled, and also under the inhibit when no error or auxiliary cause is present.
- data_rdy rises after a character reaches an empty queue, and stays up after a read that leaves entries behind.
- An arrival at a full queue with no read sets the overrun flag, and that flag holds until a clear.

Only the bench scenarios can show the oldest-first order of the data, the unchanged content after a discarded character, the per-entry error bits reaching the flags only at the head, and a clear having no effect while an errored entry is still oldest.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    parameter int RXQ_DW = 8;

    typedef struct packed {
        logic [RXQ_DW-1:0] data;
        logic              perr;
        logic              ferr;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    input  rxq_entry_t    wr_entry,
    output rxq_entry_t    head,
    output logic [CW-1:0] level,
    output logic          drop
);
    typedef struct packed {
        rxq_entry_t [DEPTH-1:0] mem;
        logic [AW-1:0]          wp;
        logic [AW-1:0]          rp;
        logic [CW-1:0]          lvl;
    } st_t;

    st_t  st_d, st_q;
    logic pop, acc, full;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        full = (st_q.lvl == CW'(DEPTH));
        pop  = pop_req & (st_q.lvl != '0);
        acc  = push_req & (~full | pop);
        drop = push_req & full & ~pop;
        if (acc) begin
            st_d.mem[st_q.wp] = wr_entry;
            st_d.wp           = nxt(st_q.wp);
        end
        if (pop) begin
            st_d.rp = nxt(st_q.rp);
        end
        st_d.lvl = st_q.lvl + CW'(acc) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rp];
    assign level = st_q.lvl;
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic nonempty,
    input  logic head_perr,
    input  logic head_ferr,
    input  logic drop,
    input  logic err_clr,
    input  logic rx_int_en,
    input  logic rdy_int_inhibit,
    input  logic aux_cause,
    output logic perr_flag,
    output logic ferr_flag,
    output logic ovr_flag,
    output logic irq,
    output logic dma_req
);
    typedef struct packed {
        logic perr;
        logic ferr;
        logic ovr;
    } flg_t;

    flg_t flg_d, flg_q;
    logic live_perr, live_ferr, any_err;

    always_comb begin
        live_perr  = nonempty & head_perr;
        live_ferr  = nonempty & head_ferr;
        flg_d.perr = (flg_q.perr & ~err_clr) | live_perr;
        flg_d.ferr = (flg_q.ferr & ~err_clr) | live_ferr;
        flg_d.ovr  = (flg_q.ovr  & ~err_clr) | drop;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign perr_flag = flg_q.perr | live_perr;
    assign ferr_flag = flg_q.ferr | live_ferr;
    assign ovr_flag  = flg_q.ovr;
    assign any_err   = perr_flag | ferr_flag | ovr_flag;
    assign dma_req   = nonempty & ~any_err;
    assign irq       = rx_int_en & ((nonempty & ~rdy_int_inhibit) | any_err | aux_cause);
endmodule

// File: rtl/rx_fifo_status.sv
module rx_fifo_status
    import rxq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chr_vld,
    input  logic [RXQ_DW-1:0] chr_data,
    input  logic              chr_perr,
    input  logic              chr_ferr,
    input  logic              rd_stb,
    input  logic              err_clr,
    input  logic              rx_int_en,
    input  logic              rdy_int_inhibit,
    input  logic              aux_cause,
    output logic [RXQ_DW-1:0] rd_data,
    output logic              rd_perr,
    output logic              rd_ferr,
    output logic              data_rdy,
    output logic              perr_flag,
    output logic              ferr_flag,
    output logic              ovr_flag,
    output logic              irq,
    output logic              dma_req
);
    rxq_entry_t    wr_entry, head;
    logic [CW-1:0] level;
    logic          drop;

    assign wr_entry = '{data: chr_data, perr: chr_perr, ferr: chr_ferr};

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (chr_vld),
        .pop_req  (rd_stb),
        .wr_entry (wr_entry),
        .head     (head),
        .level    (level),
        .drop     (drop)
    );

    assign data_rdy = (level != '0);
    assign rd_data  = head.data;
    assign rd_perr  = head.perr;
    assign rd_ferr  = head.ferr;

    rxq_flags u_flags (
        .clk             (clk),
        .rst_n           (rst_n),
        .nonempty        (data_rdy),
        .head_perr       (head.perr),
        .head_ferr       (head.ferr),
        .drop            (drop),
        .err_clr         (err_clr),
        .rx_int_en       (rx_int_en),
        .rdy_int_inhibit (rdy_int_inhibit),
        .aux_cause       (aux_cause),
        .perr_flag       (perr_flag),
        .ferr_flag       (ferr_flag),
        .ovr_flag        (ovr_flag),
        .irq             (irq),
        .dma_req         (dma_req)
    );
endmodule

// File: rtl/rx_fifo_status_chk.sv
module rx_fifo_status_chk #(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          chr_vld,
    input logic          rd_stb,
    input logic          err_clr,
    input logic          rx_int_en,
    input logic          rdy_int_inhibit,
    input logic          aux_cause,
    input logic          data_rdy,
    input logic          perr_flag,
    input logic          ferr_flag,
    input logic          ovr_flag,
    input logic          irq,
    input logic          dma_req,
    input logic [CW-1:0] level
);
    // R7
    dma_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_flag || ferr_flag || ovr_flag) |-> !dma_req);

    // R10
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_int_en |-> !irq);

    // R9
    inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_int_inhibit && !aux_cause && !perr_flag && !ferr_flag && !ovr_flag) |-> !irq);

    // R2
    rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld && !data_rdy) |=> data_rdy);

    // R3
    rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && level > CW'(1)) |=> data_rdy);

    // R4
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld && !rd_stb && level == CW'(DEPTH)) |=> ovr_flag);

    // R6
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !err_clr) |=> ovr_flag);
endmodule

bind rx_fifo_status rx_fifo_status_chk #(.DEPTH(DEPTH)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .chr_vld         (chr_vld),
    .rd_stb          (rd_stb),
    .err_clr         (err_clr),
    .rx_int_en       (rx_int_en),
    .rdy_int_inhibit (rdy_int_inhibit),
    .aux_cause       (aux_cause),
    .data_rdy        (data_rdy),
    .perr_flag       (perr_flag),
    .ferr_flag       (ferr_flag),
    .ovr_flag        (ovr_flag),
    .irq             (irq),
    .dma_req         (dma_req),
    .level           (level)
);

// File: tb/sim_rx_fifo_status.sv
`timescale 1ns/1ps
module sim_rx_fifo_status;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chr_vld = 1'b0, chr_perr = 1'b0, chr_ferr = 1'b0;
    logic [7:0] chr_data = '0;
    logic       rd_stb = 1'b0, err_clr = 1'b0;
    logic       rx_int_en = 1'b0, rdy_int_inhibit = 1'b0, aux_cause = 1'b0;
    logic [7:0] rd_data;
    logic       rd_perr, rd_ferr, data_rdy, perr_flag, ferr_flag, ovr_flag, irq, dma_req;

    int checks = 0;
    int errors = 0;
    logic [9:0] expq[$];

    always #2.5 clk = ~clk;

    rx_fifo_status #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .chr_vld(chr_vld), .chr_data(chr_data),
        .chr_perr(chr_perr), .chr_ferr(chr_ferr), .rd_stb(rd_stb), .err_clr(err_clr),
        .rx_int_en(rx_int_en), .rdy_int_inhibit(rdy_int_inhibit), .aux_cause(aux_cause),
        .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .data_rdy(data_rdy),
        .perr_flag(perr_flag), .ferr_flag(ferr_flag), .ovr_flag(ovr_flag),
        .irq(irq), .dma_req(dma_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: offers one character and records what the queue should hold
    task automatic send(input logic [7:0] d, input logic pe, input logic fe);
        @(negedge clk);
        chr_vld = 1'b1; chr_data = d; chr_perr = pe; chr_ferr = fe;
        if (expq.size() < DEPTH) expq.push_back({d, pe, fe});
        @(negedge clk);
        chr_vld = 1'b0; chr_perr = 1'b0; chr_ferr = 1'b0;
    endtask

    // monitor: compares the head with the scoreboard, then removes it
    task automatic take(input string req);
        logic [9:0] e;
        @(negedge clk);
        if (expq.size() > 0) begin
            e = expq.pop_front();
            chk(req, {rd_data, rd_perr, rd_ferr}, e);
        end
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic clear_errs();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 rdy", data_rdy, 0);
        chk("R1 flags", {perr_flag, ferr_flag, ovr_flag}, 0);
        chk("R1 req", {irq, dma_req}, 0);

        rx_int_en = 1'b1;
        send(8'hA5, 0, 0);
        chk("R2 rdy", data_rdy, 1);
        chk("R8 irq", irq, 1);
        chk("R7 dma", dma_req, 1);
        send(8'h3C, 0, 0);
        send(8'h7E, 0, 0);
        take("R2 order");
        chk("R3 rdy held", data_rdy, 1);
        chk("R3 irq held", irq, 1);
        take("R2 order");
        take("R2 order");
        chk("R3 rdy drop", data_rdy, 0);
        chk("R3 irq drop", irq, 0);

        // R11 read on empty
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
        chk("R11 rdy", data_rdy, 0);
        send(8'h11, 0, 0);
        take("R11 data");

        // R4 overrun
        for (int i = 0; i < DEPTH; i++) send(8'h40 + 8'(i), 0, 0);
        chk("R4 no ovr yet", ovr_flag, 0);
        send(8'h99, 0, 0);
        chk("R4 ovr", ovr_flag, 1);
        chk("R7 dma ovr", dma_req, 0);
        for (int i = 0; i < DEPTH; i++) take("R4 content");
        chk("R4 empty", data_rdy, 0);
        chk("R6 ovr sticky", ovr_flag, 1);
        clear_errs();
        chk("R6 ovr clr", ovr_flag, 0);

        // R9 inhibit
        rdy_int_inhibit = 1'b1;
        send(8'h55, 0, 0);
        chk("R9 no rdy irq", irq, 0);
        chk("R7 dma inh", dma_req, 1);
        aux_cause = 1'b1;
        @(negedge clk);
        chk("R9 aux irq", irq, 1);
        aux_cause = 1'b0;
        take("R2 order");

        // R5/R6 parity at head
        send(8'h66, 1, 0);
        chk("R5 perr", perr_flag, 1);
        chk("R9 err irq", irq, 1);
        chk("R7 dma perr", dma_req, 0);
        clear_errs();
        chk("R6 clr at head", perr_flag, 1);
        take("R5 entry");
        chk("R6 perr sticky", perr_flag, 1);
        clear_errs();
        chk("R6 perr clr", perr_flag, 0);

        // R5 framing behind a good char
        send(8'h21, 0, 0);
        send(8'h42, 0, 1);
        chk("R5 ferr not head", ferr_flag, 0);
        chk("R7 dma good head", dma_req, 1);
        take("R5 order");
        chk("R5 ferr head", ferr_flag, 1);
        chk("R5 rd_ferr", rd_ferr, 1);
        take("R5 entry");
        clear_errs();

        // R10
        rx_int_en = 1'b0;
        send(8'h0F, 0, 1);
        aux_cause = 1'b1;
        @(negedge clk);
        chk("R10 irq off", irq, 0);
        aux_cause = 1'b0;
        take("R10 entry");
        clear_errs();
        chk("R6 final clr", {perr_flag, ferr_flag, ovr_flag}, 0);

        finish_run();
    end
endmodule